// File: doc/BRIEF.md
# Short Branch Predication Converter

This block sits between instruction decode and issue in an in-order pipeline. Each cycle it looks at a window of four decoded instruction records, held oldest first in slots 0 to 3. When slot 0 holds a short forward conditional branch that jumps over exactly one or two plain instructions, the branch is dropped. The skipped instructions are issued as a single micro-op whose predicate is the inverse of the branch condition, so that pattern never needs a branch prediction. An unconditional branch that directly follows the issued group is folded into the same cycle. It takes no issue slot, and its displacement goes back to fetch.

A predecode hint bit that arrives with the fetch group gates the conversion. Without the hint, or when any qualifying rule fails, the conditional branch is issued unchanged as an ordinary branch micro-op. All outputs are registered, so the result for a window shows up one clock after that window is presented. A consumed count tells the fetch window how many records this cycle retired, from 0 to 4.

Top module: `brPredConv`

## Requirements
- R1: While reset is low, and at the first edge after release with an empty window, every output is zero.
- R2: Outputs are registered. A window presented before a rising edge first shows on the outputs just after that edge, and the outputs do not change between edges.
- R3: Slot 0 may hold a conditional branch (class code 3) that is short-form, with the hint set. If slot 1 is predicable (class 0 or 1) and the branch displacement equals the byte length of slot 1, then one predicated micro-op is issued with tag A taken from slot 1. Its condition is the branch condition with bit 0 flipped, and consumed is 2.
- R4: Take the same branch, but with slot 1 marked as fusing with its successor, slot 2 predicable, and a displacement equal to the sum of the lengths of slots 1 and 2. Then one predicated pair micro-op is issued with tags from slots 1 and 2, and consumed is 3.
- R5: With the hint low, a conditional branch in slot 0 is issued unchanged. The micro-op has class 3, the original condition, predicate off, and consumed is 1.
- R6: A conditional branch whose displacement matches neither body length, or which is not short-form, is issued unchanged as in R5.
- R7: If a body instruction is not predicable (class 2 for non-predicable operations, class 3 or 4 for branches), no conversion takes place and the branch is issued unchanged.
- R8: An unconditional branch (class 4) directly after an issued non-branch group is folded. jumpValid rises, jumpDisp carries its displacement, and consumed grows by one. An unconditional branch alone in slot 0 gives jumpValid with no micro-op and consumed 1.
- R9: Without a branch, when slot 0 is marked as fusing and slots 0 and 1 are both predicable, one unpredicated pair micro-op is issued and consumed is 2.
- R10: An invalid slot 0 gives no micro-op, no jump and consumed 0.
- R11: A conditional branch, a fused two-instruction body and a trailing unconditional branch all retire in one cycle with consumed 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hintIn | input | 1 | Predecode conversion hint for the fetch group |
| winValid | input | 4 | Per-slot record valid |
| winClass | input | 12 | Per-slot 3-bit class: 0 ALU, 1 load, 2 non-predicable, 3 conditional branch, 4 unconditional branch |
| winCond | input | 16 | Per-slot 4-bit condition code |
| winLen | input | 16 | Per-slot byte length (LEN_W bits each) |
| winDisp | input | 32 | Per-slot branch displacement (DISP_W bits each) |
| winFuse | input | 4 | Slot fuses with the next slot |
| winShort | input | 4 | Branch uses the byte displacement form |
| winTag | input | 32 | Per-slot instruction tag (TAG_W bits each) |
| uopValid | output | 1 | A micro-op is issued |
| uopPair | output | 1 | Micro-op carries two fused instructions |
| uopPredEn | output | 1 | Micro-op is predicated |
| uopClass | output | 3 | Class of the first instruction in the micro-op |
| uopCond | output | 4 | Predicate or branch condition |
| uopTagA | output | 8 | Tag of the first instruction |
| uopTagB | output | 8 | Tag of the second instruction, zero when unpaired |
| jumpValid | output | 1 | An unconditional branch was folded |
| jumpDisp | output | 8 | Displacement of the folded branch |
| consumed | output | 3 | Records retired from the window this cycle |

## Verification
The bench builds the block with its defaults: 4-bit lengths, 8-bit displacements, 4-bit conditions and 8-bit tags. With these, a two-instruction body sums to at most 30 bytes, so both the exact-match and the off-by-one displacement cases are reachable. Tags are distinct per slot, which shows which records were merged into each micro-op. The directed cases step through each conversion rule, each rejection reason, folding at slot 0 and after a group, and the four-record best case.

// File: rtl/brpc_pkg.sv
package brpc_pkg;
  localparam int NSLOT = 4;
  localparam logic [2:0] CLS_ALU    = 3'd0;
  localparam logic [2:0] CLS_MEM    = 3'd1;
  localparam logic [2:0] CLS_NOPRED = 3'd2;
  localparam logic [2:0] CLS_BCC    = 3'd3;
  localparam logic [2:0] CLS_BRA    = 3'd4;

  typedef struct packed {
    logic       emit;
    logic       pair;
    logic       predOn;
    logic [1:0] base;
    logic       foldJmp;
    logic [1:0] jmpSlot;
    logic [2:0] consumed;
  } strobes_t;

  function automatic logic isPredicable(input logic [2:0] cls);
    return (cls == CLS_ALU) || (cls == CLS_MEM);
  endfunction
endpackage

// File: rtl/brpcCtrl.sv
module brpcCtrl
  import brpc_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int DISP_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hintIn,
  input  logic [NSLOT-1:0]          slotValid,
  input  logic [NSLOT*3-1:0]        slotClass,
  input  logic [NSLOT-1:0]          slotFuse,
  input  logic [NSLOT-1:0]          slotShort,
  input  logic [NSLOT*LEN_W-1:0]    slotLen,
  input  logic [NSLOT*DISP_W-1:0]   slotDisp,
  output strobes_t                  stb
);
  localparam int SUM_W = LEN_W + 1;

  logic [2:0]       cls   [NSLOT];
  logic [LEN_W-1:0] len   [NSLOT];
  logic [NSLOT-1:0] pred;

  for (genvar i = 0; i < NSLOT; i++) begin : g_unpack
    assign cls[i]  = slotClass[i*3 +: 3];
    assign len[i]  = slotLen[i*LEN_W +: LEN_W];
    assign pred[i] = slotValid[i] && isPredicable(cls[i]);
  end

  logic [DISP_W-1:0] brDisp;
  logic [SUM_W-1:0]  bodyOne, bodyTwo;
  logic              candidate, convOne, convTwo, fuseNorm;

  assign brDisp    = slotDisp[DISP_W-1:0];
  assign bodyOne   = SUM_W'(len[1]);
  assign bodyTwo   = SUM_W'(len[1]) + SUM_W'(len[2]);
  assign candidate = slotValid[0] && (cls[0] == CLS_BCC) && slotShort[0] && hintIn;
  assign convTwo   = candidate && pred[1] && slotFuse[1] && pred[2] &&
                     (brDisp == DISP_W'(bodyTwo));
  assign convOne   = candidate && !convTwo && pred[1] &&
                     (brDisp == DISP_W'(bodyOne));
  assign fuseNorm  = pred[0] && slotFuse[0] && pred[1];

  logic [2:0] groupLen;
  logic       allowFold;
  logic       foldHit;

  always_comb begin
    stb       = '0;
    groupLen  = 3'd0;
    allowFold = 1'b0;
    foldHit   = 1'b0;
    if (!slotValid[0]) begin
      groupLen = 3'd0;
    end else if (convTwo) begin
      stb.emit = 1'b1; stb.pair = 1'b1; stb.predOn = 1'b1; stb.base = 2'd1;
      groupLen = 3'd3; allowFold = 1'b1;
    end else if (convOne) begin
      stb.emit = 1'b1; stb.predOn = 1'b1; stb.base = 2'd1;
      groupLen = 3'd2; allowFold = 1'b1;
    end else if (cls[0] == CLS_BRA) begin
      stb.foldJmp = 1'b1; stb.jmpSlot = 2'd0;
      groupLen = 3'd1;
    end else if (cls[0] == CLS_BCC) begin
      stb.emit = 1'b1;
      groupLen = 3'd1;
    end else if (fuseNorm) begin
      stb.emit = 1'b1; stb.pair = 1'b1;
      groupLen = 3'd2; allowFold = 1'b1;
    end else begin
      stb.emit = 1'b1;
      groupLen = 3'd1; allowFold = 1'b1;
    end
    if (allowFold && slotValid[groupLen[1:0]] && (cls[groupLen[1:0]] == CLS_BRA)) begin
      foldHit     = 1'b1;
      stb.foldJmp = 1'b1;
      stb.jmpSlot = groupLen[1:0];
    end
    stb.consumed = groupLen + {2'b00, foldHit};
  end

  AST_PRED_NEEDS_HINT: assert property (@(posedge clk) disable iff (!rstN)
    stb.predOn |-> hintIn);  // R5
  AST_PRED_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    stb.predOn |-> slotShort[0]);  // R6
  AST_CONSUMED_MAX: assert property (@(posedge clk) disable iff (!rstN)
    stb.consumed <= 3'd4);  // R11
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid[0] |-> (stb.consumed == 3'd0));  // R10
endmodule

// File: rtl/brpcData.sv
module brpcData
  import brpc_pkg::*;
#(
  parameter int DISP_W = 8,
  parameter int COND_W = 4,
  parameter int TAG_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  stb,
  input  logic [NSLOT*3-1:0]        slotClass,
  input  logic [NSLOT*COND_W-1:0]   slotCond,
  input  logic [NSLOT*DISP_W-1:0]   slotDisp,
  input  logic [NSLOT*TAG_W-1:0]    slotTag,
  output logic                      uopValid,
  output logic                      uopPair,
  output logic                      uopPredEn,
  output logic [2:0]                uopClass,
  output logic [COND_W-1:0]         uopCond,
  output logic [TAG_W-1:0]          uopTagA,
  output logic [TAG_W-1:0]          uopTagB,
  output logic                      jumpValid,
  output logic [DISP_W-1:0]         jumpDisp,
  output logic [2:0]                consumed
);
  logic [2:0]        cls  [NSLOT];
  logic [TAG_W-1:0]  tag  [NSLOT];
  logic [DISP_W-1:0] disp [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_unpack
    assign cls[i]  = slotClass[i*3 +: 3];
    assign tag[i]  = slotTag[i*TAG_W +: TAG_W];
    assign disp[i] = slotDisp[i*DISP_W +: DISP_W];
  end

  logic [1:0]        nextSlot;
  logic [COND_W-1:0] brCond;
  logic              passBranch;

  assign nextSlot   = stb.base + 2'd1;
  assign brCond     = slotCond[COND_W-1:0];
  assign passBranch = stb.emit && !stb.predOn && (stb.base == 2'd0) && (cls[0] == CLS_BCC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uopValid  <= 1'b0;
      uopPair   <= 1'b0;
      uopPredEn <= 1'b0;
      uopClass  <= '0;
      uopCond   <= '0;
      uopTagA   <= '0;
      uopTagB   <= '0;
      jumpValid <= 1'b0;
      jumpDisp  <= '0;
      consumed  <= '0;
    end else begin
      uopValid  <= stb.emit;
      uopPair   <= stb.pair;
      uopPredEn <= stb.predOn;
      uopClass  <= stb.emit ? cls[stb.base] : 3'd0;
      uopTagA   <= stb.emit ? tag[stb.base] : '0;
      uopTagB   <= stb.pair ? tag[nextSlot] : '0;
      if (stb.predOn)      uopCond <= brCond ^ COND_W'(1);
      else if (passBranch) uopCond <= brCond;
      else                 uopCond <= '0;
      jumpValid <= stb.foldJmp;
      jumpDisp  <= stb.foldJmp ? disp[stb.jmpSlot] : '0;
      consumed  <= stb.consumed;
    end
  end

  AST_PRED_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    uopPredEn |-> uopValid);  // R3
  AST_PRED_FROM_BCC: assert property (@(posedge clk) disable iff (!rstN)
    uopPredEn |-> ($past(cls[0]) == CLS_BCC));  // R3
  AST_PAIR_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    uopPair |-> uopValid);  // R4
  AST_RETIRE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid || jumpValid) |-> (consumed != 3'd0));  // R8
endmodule

// File: rtl/brPredConv.sv
module brPredConv
  import brpc_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int DISP_W = 8,
  parameter int COND_W = 4,
  parameter int TAG_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hintIn,
  input  logic [3:0]                winValid,
  input  logic [11:0]               winClass,
  input  logic [4*COND_W-1:0]       winCond,
  input  logic [4*LEN_W-1:0]        winLen,
  input  logic [4*DISP_W-1:0]       winDisp,
  input  logic [3:0]                winFuse,
  input  logic [3:0]                winShort,
  input  logic [4*TAG_W-1:0]        winTag,
  output logic                      uopValid,
  output logic                      uopPair,
  output logic                      uopPredEn,
  output logic [2:0]                uopClass,
  output logic [COND_W-1:0]         uopCond,
  output logic [TAG_W-1:0]          uopTagA,
  output logic [TAG_W-1:0]          uopTagB,
  output logic                      jumpValid,
  output logic [DISP_W-1:0]         jumpDisp,
  output logic [2:0]                consumed
);
  strobes_t stb;

  brpcCtrl #(.LEN_W(LEN_W), .DISP_W(DISP_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hintIn(hintIn),
    .slotValid(winValid), .slotClass(winClass), .slotFuse(winFuse),
    .slotShort(winShort), .slotLen(winLen), .slotDisp(winDisp),
    .stb(stb)
  );

  brpcData #(.DISP_W(DISP_W), .COND_W(COND_W), .TAG_W(TAG_W)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .slotClass(winClass), .slotCond(winCond), .slotDisp(winDisp), .slotTag(winTag),
    .uopValid(uopValid), .uopPair(uopPair), .uopPredEn(uopPredEn),
    .uopClass(uopClass), .uopCond(uopCond), .uopTagA(uopTagA), .uopTagB(uopTagB),
    .jumpValid(jumpValid), .jumpDisp(jumpDisp), .consumed(consumed)
  );
endmodule

// File: tb/test_brPredConv.sv
module test_brPredConv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hintIn = 1'b0;
  logic [3:0]  winValid = '0;
  logic [11:0] winClass = '0;
  logic [15:0] winCond = '0;
  logic [15:0] winLen = '0;
  logic [31:0] winDisp = '0;
  logic [3:0]  winFuse = '0;
  logic [3:0]  winShort = '0;
  logic [31:0] winTag = '0;
  logic        uopValid, uopPair, uopPredEn, jumpValid;
  logic [2:0]  uopClass, consumed;
  logic [3:0]  uopCond;
  logic [7:0]  uopTagA, uopTagB, jumpDisp;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  brPredConv i_brPredConv (
    .clk(clk), .rstN(rstN), .hintIn(hintIn),
    .winValid(winValid), .winClass(winClass), .winCond(winCond), .winLen(winLen),
    .winDisp(winDisp), .winFuse(winFuse), .winShort(winShort), .winTag(winTag),
    .uopValid(uopValid), .uopPair(uopPair), .uopPredEn(uopPredEn),
    .uopClass(uopClass), .uopCond(uopCond), .uopTagA(uopTagA), .uopTagB(uopTagB),
    .jumpValid(jumpValid), .jumpDisp(jumpDisp), .consumed(consumed)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearWin();
    hintIn = 1'b0; winValid = '0; winClass = '0; winCond = '0; winLen = '0;
    winDisp = '0; winFuse = '0; winShort = '0; winTag = '0;
  endtask

  task automatic setSlot(input int s, input logic [2:0] c, input logic [3:0] cd,
                         input logic [3:0] ln, input logic [7:0] dp, input logic fu,
                         input logic sh);
    winValid[s] = 1'b1;
    winClass[s*3 +: 3] = c;
    winCond[s*4 +: 4] = cd;
    winLen[s*4 +: 4] = ln;
    winDisp[s*8 +: 8] = dp;
    winFuse[s] = fu;
    winShort[s] = sh;
    winTag[s*8 +: 8] = 8'(8'h10 * (s + 1) + 1);
  endtask

  function automatic int tagOf(input int s);
    return 16 * (s + 1) + 1;
  endfunction

  // Present the window at a falling edge, results read at the next falling edge.
  task automatic present();
    @(negedge clk);
  endtask

  task automatic expectPass(input string req, input int cond);
    chk(req, "uopValid", uopValid, 1);
    chk(req, "uopClass", uopClass, 3);
    chk(req, "uopPredEn", uopPredEn, 0);
    chk(req, "uopCond", uopCond, cond);
    chk(req, "consumed", consumed, 1);
  endtask

  task automatic tReset();
    chk("R1", "uopValid in reset", uopValid, 0);
    chk("R1", "consumed in reset", consumed, 0);
    @(negedge clk); rstN = 1'b1; clearWin();
    present();
    chk("R1", "uopValid", uopValid, 0);
    chk("R1", "jumpValid", jumpValid, 0);
    chk("R1", "uopTagA", uopTagA, 0);
    chk("R1", "consumed", consumed, 0);
  endtask

  task automatic tLatency();
    clearWin(); setSlot(0, 3'd0, 4'h0, 4'd2, 8'd0, 1'b0, 1'b0);
    #1;
    chk("R2", "before edge uopValid", uopValid, 0);
    present();
    chk("R2", "after edge uopValid", uopValid, 1);
    chk("R2", "after edge tagA", uopTagA, tagOf(0));
    chk("R2", "after edge consumed", consumed, 1);
  endtask

  task automatic tConvOne();
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'h6, 4'd2, 8'd4, 1'b0, 1'b1);
    setSlot(1, 3'd1, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    setSlot(2, 3'd0, 4'h0, 4'd2, 8'd0, 1'b0, 1'b0);
    present();
    chk("R3", "uopValid", uopValid, 1);
    chk("R3", "uopPredEn", uopPredEn, 1);
    chk("R3", "uopCond inverted", uopCond, 7);
    chk("R3", "uopTagA", uopTagA, tagOf(1));
    chk("R3", "uopPair", uopPair, 0);
    chk("R3", "consumed", consumed, 2);
    chk("R3", "jumpValid", jumpValid, 0);
  endtask

  task automatic tConvPair();
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'h7, 4'd2, 8'd8, 1'b0, 1'b1);
    setSlot(1, 3'd0, 4'h0, 4'd2, 8'd0, 1'b1, 1'b0);
    setSlot(2, 3'd1, 4'h0, 4'd6, 8'd0, 1'b0, 1'b0);
    present();
    chk("R4", "uopPredEn", uopPredEn, 1);
    chk("R4", "uopCond inverted", uopCond, 6);
    chk("R4", "uopPair", uopPair, 1);
    chk("R4", "uopTagA", uopTagA, tagOf(1));
    chk("R4", "uopTagB", uopTagB, tagOf(2));
    chk("R4", "consumed", consumed, 3);
  endtask

  task automatic tNoHint();
    clearWin(); hintIn = 1'b0;
    setSlot(0, 3'd3, 4'h6, 4'd2, 8'd4, 1'b0, 1'b1);
    setSlot(1, 3'd1, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    present();
    expectPass("R5", 6);
  endtask

  task automatic tMismatch();
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'hA, 4'd2, 8'd5, 1'b0, 1'b1);
    setSlot(1, 3'd1, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    present();
    expectPass("R6", 10);
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'hA, 4'd4, 8'd4, 1'b0, 1'b0);
    setSlot(1, 3'd1, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    present();
    expectPass("R6", 10);
  endtask

  task automatic tBadBody();
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'h6, 4'd2, 8'd4, 1'b0, 1'b1);
    setSlot(1, 3'd2, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    present();
    expectPass("R7", 6);
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'h6, 4'd2, 8'd2, 1'b0, 1'b1);
    setSlot(1, 3'd3, 4'h2, 4'd2, 8'd0, 1'b0, 1'b1);
    present();
    expectPass("R7", 6);
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'h6, 4'd2, 8'd6, 1'b0, 1'b1);
    setSlot(1, 3'd0, 4'h0, 4'd2, 8'd0, 1'b1, 1'b0);
    setSlot(2, 3'd4, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    present();
    expectPass("R7", 6);
  endtask

  task automatic tFold();
    clearWin();
    setSlot(0, 3'd4, 4'h0, 4'd2, 8'd40, 1'b0, 1'b1);
    setSlot(1, 3'd0, 4'h0, 4'd2, 8'd0, 1'b0, 1'b0);
    present();
    chk("R8", "lone bra uopValid", uopValid, 0);
    chk("R8", "lone bra jumpValid", jumpValid, 1);
    chk("R8", "lone bra jumpDisp", jumpDisp, 40);
    chk("R8", "lone bra consumed", consumed, 1);
    clearWin();
    setSlot(0, 3'd0, 4'h0, 4'd2, 8'd0, 1'b0, 1'b0);
    setSlot(1, 3'd4, 4'h0, 4'd2, 8'd200, 1'b0, 1'b1);
    present();
    chk("R8", "after alu uopValid", uopValid, 1);
    chk("R8", "after alu jumpValid", jumpValid, 1);
    chk("R8", "after alu jumpDisp", jumpDisp, 200);
    chk("R8", "after alu consumed", consumed, 2);
  endtask

  task automatic tFuseNormal();
    clearWin();
    setSlot(0, 3'd0, 4'h0, 4'd2, 8'd0, 1'b1, 1'b0);
    setSlot(1, 3'd1, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    present();
    chk("R9", "uopPair", uopPair, 1);
    chk("R9", "uopPredEn", uopPredEn, 0);
    chk("R9", "uopTagB", uopTagB, tagOf(1));
    chk("R9", "consumed", consumed, 2);
  endtask

  task automatic tEmpty();
    clearWin();
    winValid[1] = 1'b1;
    present();
    chk("R10", "uopValid", uopValid, 0);
    chk("R10", "jumpValid", jumpValid, 0);
    chk("R10", "consumed", consumed, 0);
  endtask

  task automatic tBest();
    clearWin(); hintIn = 1'b1;
    setSlot(0, 3'd3, 4'h6, 4'd2, 8'd6, 1'b0, 1'b1);
    setSlot(1, 3'd0, 4'h0, 4'd2, 8'd0, 1'b1, 1'b0);
    setSlot(2, 3'd1, 4'h0, 4'd4, 8'd0, 1'b0, 1'b0);
    setSlot(3, 3'd4, 4'h0, 4'd2, 8'd100, 1'b0, 1'b1);
    present();
    chk("R11", "uopPredEn", uopPredEn, 1);
    chk("R11", "uopPair", uopPair, 1);
    chk("R11", "jumpValid", jumpValid, 1);
    chk("R11", "jumpDisp", jumpDisp, 100);
    chk("R11", "consumed", consumed, 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    clearWin();
    repeat (3) @(negedge clk);
    tReset();
    tLatency();
    tConvOne();
    tConvPair();
    tNoHint();
    tMismatch();
    tBadBody();
    tFold();
    tFuseNormal();
    tEmpty();
    tBest();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule